// File: doc/BRIEF.md
# Period and Duty PWM Output Channel

This block generates one pulse-width-modulated pin signal. An up-counter runs on the system clock but moves only on cycles where a clock-enable strobe from an external prescaler is high, so one strobe interval sets the time resolution. A period value gives the number of strobes per cycle of the waveform. A duty value gives how many of those strobes, counted from the start of each cycle, the waveform spends at its active level. A polarity input chooses whether the active level appears at the pin as high or as low.

When the channel enable is low, the counter is held at zero and the pin carries a general-purpose data bit instead of the waveform. Software may change the period and duty inputs at any time. While the channel runs, new values are taken only at the end of a waveform cycle, so a cycle is never cut short or stretched by a change that arrives in the middle of it.

Control is a three-state machine. `ST_DIS` means the channel is disabled and the pin shows the data bit. `ST_ON` means the waveform is in its active phase. `ST_OFFT` means it is in its inactive phase. The transitions are: *enable* (`ST_DIS` to `ST_ON` or `ST_OFFT`, chosen from count 0), *duty-end* (`ST_ON` to `ST_OFFT` when the next count reaches the duty value), *period-wrap* (back to `ST_ON` when the count returns to 0 and the duty is non-zero), *hold* (no strobe, so no change), and *disable* (any state to `ST_DIS` when the enable is low).

Top module: `pwm_chan`

## Requirements
- R1: The counter advances by one only on clock cycles where `tick` is high. With a period value P of at least 1, it counts 0, 1, ..., P-1 and then returns to 0. One waveform cycle therefore lasts exactly P strobes.
- R2: With P of at least 1 and duty value D, the waveform is active while the count is below D. D = 0 keeps it inactive for the whole cycle. D >= P keeps it active for the whole cycle.
- R3: A period value of 0 holds the count at 0 and keeps the waveform inactive for as long as it stays 0.
- R4: `pol_lo` = 0 drives the active level as 1 on `pin`. `pol_lo` = 1 drives the active level as 0.
- R5: One clock after `en` is sampled low, the channel is disabled. The count becomes 0 and `pin` follows `gpio_bit` combinationally. One clock after `en` is sampled high again, the channel runs from count 0.
- R6: While the channel runs, `per_in` and `dty_in` are captured only when the count wraps to 0. While it is disabled, they are captured on every clock.
- R7: After the asynchronous reset `rst_n` is released, the channel is disabled, so `pin` equals `gpio_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count strobe from the prescaler |
| en | input | 1 | Channel enable |
| pol_lo | input | 1 | 1 selects an active-low pulse at the pin |
| per_in | input | 8 | Period value, in strobes |
| dty_in | input | 8 | Duty value, in strobes |
| gpio_bit | input | 1 | Data bit shown on the pin while disabled |
| pin | output | 1 | Pin drive |

## Verification
The main function is swept over every period value from 0 to 12, every duty value from 0 to 14 and both polarities, with a strobe on every clock. The bench computes the expected pin value from the number of strobes applied since enable. This sweep separates the duty-below-period case from the always-on case (duty at or above period) and from the always-off cases (period or duty of 0). A second pattern sends a strobe on only one clock in three, which shows that the counter does not move between strobes. A third pattern changes the period and duty in the middle of a cycle, which shows whether new values take effect at the wrap or too early. Between configurations the channel is disabled, which exercises the data-bit passthrough and the clean restart from count 0.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    typedef enum logic [1:0] {
        ST_DIS  = 2'd0,
        ST_ON   = 2'd1,
        ST_OFFT = 2'd2
    } pwm_state_t;
endpackage

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         run,
    input  logic         tick,
    input  logic         wrap,
    input  logic [W-1:0] per_in,
    input  logic [W-1:0] dty_in,
    output logic [W-1:0] per_s,
    output logic [W-1:0] dty_s,
    output logic [W-1:0] per_n,
    output logic [W-1:0] dty_n
);
    logic load;

    assign load  = !run || (tick && wrap);
    assign per_n = load ? per_in : per_s;
    assign dty_n = load ? dty_in : dty_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_s <= '0;
            dty_s <= '0;
        end else begin
            per_s <= per_n;
            dty_s <= dty_n;
        end
    end

    // R6
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && run && !(tick && wrap)) |=> ($stable(per_s) && $stable(dty_s)));
endmodule

// File: rtl/pwm_cnt.sv
module pwm_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] per_s,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_nxt,
    output logic         wrap
);
    localparam logic [W-1:0] ONE = W'(1);

    assign wrap    = (per_s == '0) || (cnt == per_s - ONE);
    assign cnt_nxt = wrap ? '0 : cnt + ONE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (!en || !run)  cnt <= '0;
        else if (tick)         cnt <= cnt_nxt;
    end

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && per_s != '0) |-> (cnt < per_s));
    // R1
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick) |=> $stable(cnt));
    // R3
    per_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (per_s == '0) |-> (cnt == '0));
endmodule

// File: rtl/pwm_fsm.sv
module pwm_fsm
    import pwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         tick,
    input  logic         pol_lo,
    input  logic         gpio_bit,
    input  logic [W-1:0] cnt_nxt,
    input  logic [W-1:0] per_n,
    input  logic [W-1:0] dty_n,
    input  logic [W-1:0] dty_s,
    output logic         run,
    output logic         pin
);
    pwm_state_t state, state_nxt;

    function automatic pwm_state_t phase_of(logic [W-1:0] c, logic [W-1:0] p, logic [W-1:0] d);
        return ((p != '0) && (c < d)) ? ST_ON : ST_OFFT;
    endfunction

    always_comb begin
        state_nxt = state;
        if (!en) begin
            state_nxt = ST_DIS;
        end else begin
            unique case (state)
                ST_DIS:          state_nxt = phase_of('0, per_n, dty_n);
                ST_ON, ST_OFFT:  if (tick) state_nxt = phase_of(cnt_nxt, per_n, dty_n);
                default:         state_nxt = ST_DIS;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_DIS;
        else        state <= state_nxt;
    end

    always_comb begin
        run = (state != ST_DIS);
        unique case (state)
            ST_ON:   pin = !pol_lo;
            ST_OFFT: pin = pol_lo;
            default: pin = gpio_bit;
        endcase
    end

    // R2
    duty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && dty_s == '0) |-> (state == ST_OFFT));
    // R5
    dis_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == ST_DIS));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         en,
    input  logic         pol_lo,
    input  logic [W-1:0] per_in,
    input  logic [W-1:0] dty_in,
    input  logic         gpio_bit,
    output logic         pin
);
    logic         run, wrap;
    logic [W-1:0] cnt, cnt_nxt, per_s, dty_s, per_n, dty_n;

    pwm_shadow #(.W(W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .en(en), .run(run), .tick(tick), .wrap(wrap),
        .per_in(per_in), .dty_in(dty_in),
        .per_s(per_s), .dty_s(dty_s), .per_n(per_n), .dty_n(dty_n)
    );

    pwm_cnt #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(en), .run(run), .tick(tick),
        .per_s(per_s), .cnt(cnt), .cnt_nxt(cnt_nxt), .wrap(wrap)
    );

    pwm_fsm #(.W(W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .pol_lo(pol_lo),
        .gpio_bit(gpio_bit), .cnt_nxt(cnt_nxt), .per_n(per_n), .dty_n(dty_n),
        .dty_s(dty_s), .run(run), .pin(pin)
    );

    // R5
    pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (pin == gpio_bit && cnt == '0));
endmodule

// File: tb/tb_pwm_chan.sv
module tb_pwm_chan;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       en = 1'b0;
    logic       pol_lo = 1'b0;
    logic [7:0] per_in = '0;
    logic [7:0] dty_in = '0;
    logic       gpio_bit = 1'b0;
    logic       pin;

    int n_run = 0;
    int n_fail = 0;

    pwm_chan dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .pol_lo(pol_lo),
        .per_in(per_in), .dty_in(dty_in), .gpio_bit(gpio_bit), .pin(pin)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input logic got, input logic exp, input string req);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: pin=%0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic exp_pin(int p, int d, int c, logic pl);
        logic act;
        act = (p != 0) && (c < d);
        return act ^ pl;
    endfunction

    // Disable, program values, check passthrough, then enable.
    task automatic restart(input int p, input int d, input logic pl, input string req);
        @(negedge clk);
        en = 1'b0; tick = 1'b0;
        per_in = 8'(p); dty_in = 8'(d); pol_lo = pl;
        @(negedge clk);
        gpio_bit = 1'b1; #1;
        chk(pin, 1'b1, "R5 passthrough high");
        gpio_bit = 1'b0; #1;
        chk(pin, 1'b0, "R5 passthrough low");
        en = 1'b1;
        @(negedge clk);
    endtask

    // Run with a strobe every 'gap' clocks, checking each clock.
    task automatic run_cfg(input int p, input int d, input logic pl, input int gap,
                           input int ncyc, input string req);
        int n;
        n = 0;
        restart(p, d, pl, req);
        for (int k = 0; k < ncyc; k++) begin
            chk(pin, exp_pin(p, d, (p == 0) ? 0 : n % p, pl), req);
            tick = ((k % gap) == gap - 1);
            if (tick) n++;
            @(negedge clk);
        end
        tick = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R7: after reset the pin shows the data bit
        #(CLK_PERIOD * 3);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pin, 1'b0, "R7 reset low");
        gpio_bit = 1'b1; #1;
        chk(pin, 1'b1, "R7 reset high");
        gpio_bit = 1'b0;

        // R2 R3 R4 R5: sweep period, duty and polarity, strobe every clock
        for (int p = 0; p <= 12; p++)
            for (int d = 0; d <= 14; d++)
                for (int pl = 0; pl < 2; pl++)
                    run_cfg(p, d, 1'(pl), 1, 2 * p + 3, "R2/R3/R4 sweep");

        // R1: strobe on one clock in three
        run_cfg(5, 2, 1'b0, 3, 40, "R1 sparse strobe");
        run_cfg(4, 3, 1'b1, 3, 30, "R1 sparse strobe low");

        // R6: mid-cycle change takes effect only at the wrap
        begin
            int n;
            n = 0;
            restart(10, 3, 1'b0, "R6");
            for (int k = 0; k < 30; k++) begin
                if (n < 10) chk(pin, exp_pin(10, 3, n, 1'b0), "R6 old values kept");
                else        chk(pin, exp_pin(6, 5, (n - 10) % 6, 1'b0), "R6 new values at wrap");
                if (n == 4) begin per_in = 8'd6; dty_in = 8'd5; end
                tick = 1'b1;
                n++;
                @(negedge clk);
            end
            tick = 1'b0;
        end

        // R5: disable mid-cycle, then restart from count 0
        run_cfg(7, 4, 1'b0, 1, 5, "R5 pre-disable");
        @(negedge clk);
        en = 1'b0; gpio_bit = 1'b1;
        @(negedge clk);
        chk(pin, 1'b1, "R5 disable shows data bit");
        per_in = 8'd3; dty_in = 8'd1;
        @(negedge clk);
        chk(pin, 1'b1, "R5 inputs ignored while disabled");
        en = 1'b1; tick = 1'b1;
        @(negedge clk);
        chk(pin, 1'b1, "R5 restart count 0 active");
        @(negedge clk);
        chk(pin, 1'b0, "R5 restart count 1 inactive");
        tick = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule